// File: doc/BRIEF.md
# Prescaled Countdown Timer with Start/Stop Control

This block is a countdown timer that software drives over a simple register bus. The bus has a chip select, a write enable, a word address, 32-bit write data and 32-bit read data. Software first writes a prescaler reload value and a starting count while the timer is idle. It then sets the start bit in the control word. While the timer runs, a prescaler counter divides the system clock. The count drops by one each time the prescaler period ends. When the count reaches zero, the timer halts by itself.

Software can poll the run flag and read the live count at any time. It can also halt the count early with the stop bit. The start bit only acts when the timer is idle, and the stop bit only acts when it is running. Writes to the prescaler and count registers are dropped while the timer runs, so the configuration cannot change under a running count. A later start resumes from the frozen count with a fresh prescaler period.

Top module: `tmr_countdown`

## Requirements
- R1: After reset, the status, prescaler and count registers all read as zero and the timer is idle.
- R2: Word address 8 is the control register (write-only, reads 0), 9 is status, 10 is the prescaler and 11 is the count. Any other address reads 0, rdata is 0 whenever cs is low or we is high, and the read value follows the address in the same cycle.
- R3: A control write with bit 0 set, made while the timer is idle and the count is nonzero, makes the timer run from the next cycle.
- R4: A control write with bit 1 set, made while the timer is running, makes it idle from the next cycle. The count keeps the value it had, even if a prescaler period ends in that same cycle.
- R5: Control bit 0 written while running has no effect (the timer keeps running and the prescaler phase is not restarted). Control bit 1 written while idle has no effect. A control word of 3 starts an idle timer and stops a running one.
- R6: Status bit 0 reads 1 exactly while the timer is running; status bits 31..1 read 0.
- R7: A prescaler write made while idle is stored and read back. A prescaler write made while running is discarded.
- R8: A count write made while idle is stored and read back. A count write made while running is discarded. A count read always returns the live value.
- R9: Starting with prescaler value P loads the prescaler counter with P. The count then drops by one every P+1 clock cycles, with the first drop P+1 cycles after the start write's edge. P=0 drops the count on every cycle.
- R10: When the count steps from 1 to 0, the timer goes idle in the same edge, and status reads 0 with the count at 0.
- R11: A start request while the count is zero leaves the timer idle.
- R12: Restarting after an early stop resumes from the frozen count, with a full prescaler period before the next drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Register bus chip select |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid in the same cycle as the address |

## Verification
The bench goes after the exact cycle of each count step. It checks the first step after a start, a prescaler of zero, and the step from 1 to 0. A design with an off-by-one prescaler would drift out of step with the reference model. A design that checks for zero too late would show a wrapped count of all ones. The bench also lands a stop on the same edge as a prescaler expiry, where a wrong design loses one count. It sends a start to a timer that is already running and sees whether the prescaler phase restarts. It writes the prescaler and count while running, which would corrupt the live value if those writes were not blocked. It also starts with a count of zero, which a wrong design would treat as a run that wraps through the full range.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_CTRL  = 8;
  localparam int unsigned REG_STAT  = 9;
  localparam int unsigned REG_PRESC = 10;
  localparam int unsigned REG_VALUE = 11;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic presc_we;
    logic value_we;
  } tmr_cmd_t;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 32,
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               running,
  input  logic [COUNT_W-1:0] count,
  output tmr_cmd_t           cmd,
  output logic [PRESC_W-1:0] presc_cfg,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(REG_PRESC);
  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(REG_VALUE);

  logic               wr_acc;
  logic               rd_acc;
  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W-1:0] presc_d;
  logic               presc_en;

  // Command decode: each request is qualified by the current run state.
  always_comb begin
    wr_acc       = cs & we;
    rd_acc       = cs & ~we;
    cmd.start    = wr_acc & (addr == A_CTRL) & wdata[CTRL_START_BIT] & ~running;
    cmd.stop     = wr_acc & (addr == A_CTRL) & wdata[CTRL_STOP_BIT] & running;
    cmd.presc_we = wr_acc & (addr == A_PRESC) & ~running;
    cmd.value_we = wr_acc & (addr == A_VALUE) & ~running;
  end

  always_comb begin
    presc_en = cmd.presc_we;
    presc_d  = wdata[PRESC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (presc_en) begin
      presc_q <= presc_d;
    end
  end

  assign presc_cfg = presc_q;

  // Same-cycle read path, zero-extended to the bus width.
  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      unique case (addr)
        A_STAT:  rdata = DATA_W'(running);
        A_PRESC: rdata = DATA_W'(presc_q);
        A_VALUE: rdata = DATA_W'(count);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRESC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               running,
  input  logic [PRESC_W-1:0] reload,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] cnt_d;
  logic               cnt_en;
  logic               expired;

  always_comb begin
    expired = (cnt_q == '0);
    tick    = running & expired;
    cnt_en  = start | running;
    if (start || expired) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               tick,
  input  logic               load_en,
  input  logic [COUNT_W-1:0] load_val,
  output logic               running,
  output logic [COUNT_W-1:0] value
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic               run_q;
  logic               run_d;
  logic [COUNT_W-1:0] val_q;
  logic [COUNT_W-1:0] val_d;
  logic               val_en;
  logic               step;

  always_comb begin
    step   = tick & ~stop;
    val_en = load_en | step;
    val_d  = load_en ? load_val : (val_q - 1'b1);
    run_d  = run_q;
    if (stop) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d = (val_q != '0);
    end else if (step && (val_q == ONE)) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign running = run_q;
  assign value   = val_q;
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 32,
  parameter int unsigned COUNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic               rst_meta_q;
  logic               rst_q_n;
  tmr_cmd_t           cmd;
  logic [PRESC_W-1:0] presc_w;
  logic               run_w;
  logic [COUNT_W-1:0] value_w;
  logic               tick_w;

  // Reset asserts at once, releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  tmr_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRESC_W(PRESC_W),
    .COUNT_W(COUNT_W)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cs       (cs),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .running  (run_w),
    .count    (value_w),
    .cmd      (cmd),
    .presc_cfg(presc_w),
    .rdata    (rdata)
  );

  tmr_prescaler #(
    .PRESC_W(PRESC_W)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .start  (cmd.start),
    .running(run_w),
    .reload (presc_w),
    .tick   (tick_w)
  );

  tmr_counter #(
    .COUNT_W(COUNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start   (cmd.start),
    .stop    (cmd.stop),
    .tick    (tick_w),
    .load_en (cmd.value_we),
    .load_val(wdata[COUNT_W-1:0]),
    .running (run_w),
    .value   (value_w)
  );
endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRESC_W = 32,
  parameter int unsigned COUNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs,
  input logic               we,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               running,
  input logic [COUNT_W-1:0] value,
  input logic [PRESC_W-1:0] presc_cfg
);
  logic ctrl_wr;
  assign ctrl_wr = cs && we && (addr == ADDR_W'(REG_CTRL));

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[0] && !running && (value != '0) |=> running); // R3
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[1] && running |=> !running && (value == $past(value))); // R4
  AST_STAYS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    running && !(ctrl_wr && wdata[1]) && (value > COUNT_W'(1)) |=> running); // R5
  AST_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !(ctrl_wr && wdata[0]) |=> !running); // R5
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cs && !we && (addr == ADDR_W'(REG_STAT)) |-> rdata == DATA_W'(running)); // R6
  AST_PRESC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(presc_cfg)); // R7
  AST_VALUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (value == $past(value)) || (value == $past(value) - 1'b1)); // R8
  AST_NONZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> value != '0); // R10
  AST_ZERO_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    !running && (value == '0) |=> !running); // R11
endmodule

bind tmr_countdown tmr_countdown_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PRESC_W(PRESC_W),
  .COUNT_W(COUNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .cs       (cs),
  .we       (we),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .running  (run_w),
  .value    (value_w),
  .presc_cfg(presc_w)
);

// File: tb/tmr_countdown_test.sv
`timescale 1ns/1ps
module tmr_countdown_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int A_CTRL = 8, A_STAT = 9, A_PRESC = 10, A_VALUE = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit          m_run;
  bit [31:0]   m_pres, m_val, m_pcnt;

  tmr_countdown uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pres = 0; m_val = 0; m_pcnt = 0;
    end else begin
      bit o_run; bit [31:0] o_pres, o_val, o_pcnt;
      bit wr_ctrl;
      o_run = m_run; o_pres = m_pres; o_val = m_val; o_pcnt = m_pcnt;
      wr_ctrl = cs && we && (addr == A_CTRL);
      if (!o_run) begin
        if (wr_ctrl && wdata[0]) begin
          m_pcnt = o_pres;
          m_run  = (o_val != 0);
        end
        if (cs && we && addr == A_PRESC) m_pres = wdata;
        if (cs && we && addr == A_VALUE) m_val = wdata;
      end else if (wr_ctrl && wdata[1]) begin
        m_run = 0;
      end else if (o_pcnt == 0) begin
        m_val  = o_val - 1;
        m_pcnt = o_pres;
        if (o_val == 1) m_run = 0;
      end else begin
        m_pcnt = o_pcnt - 1;
      end
    end
  end

  // Compare the read port against the model on every cycle
  always @(negedge clk) begin
    logic [31:0] exp;
    string tag;
    exp = 0; tag = "R2";
    if (cs && !we) begin
      case (addr)
        A_STAT:  begin exp = {31'b0, m_run}; tag = "R6"; end
        A_PRESC: begin exp = m_pres; tag = "R7"; end
        A_VALUE: begin exp = m_val;  tag = "R8"; end
        default: exp = 0;
      endcase
    end
    check(tag, rdata, exp);
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    cs = 1; we = 1; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    cs = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(posedge clk); #1;
    cs = 1; we = 0; addr = AW'(a);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    cs = 0; we = 0;
    repeat (n - 1) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, held;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset values
    rd(A_STAT, v);  check("R1", v, 0);
    rd(A_PRESC, v); check("R1", v, 0);
    rd(A_VALUE, v); check("R1", v, 0);

    // R2 map: control and unused addresses read zero
    wr(A_PRESC, 32'h5);
    rd(A_PRESC, v); check("R7", v, 5);
    rd(A_CTRL, v);  check("R2", v, 0);
    rd(0, v);       check("R2", v, 0);
    rd(63, v);      check("R2", v, 0);

    // R11 start with zero count
    wr(A_CTRL, 1);
    rd(A_STAT, v);  check("R11", v, 0);

    // R9/R10 exact timing: P=2, T=3 stops 9 edges after start
    wr(A_PRESC, 2);
    wr(A_VALUE, 3);
    rd(A_VALUE, v); check("R8", v, 3);
    wr(A_CTRL, 1);
    rd(A_STAT, v);  check("R3", v, 1);
    idle(6);
    rd(A_VALUE, v); check("R9", v, 1);
    rd(A_VALUE, v); check("R10", v, 0);
    rd(A_STAT, v);  check("R10", v, 0);

    // R7/R8/R5 writes while running
    wr(A_PRESC, 1);
    wr(A_VALUE, 10);
    wr(A_CTRL, 1);
    idle(3);
    wr(A_PRESC, 7);
    wr(A_VALUE, 99);
    rd(A_PRESC, v); check("R7", v, 1);
    rd(A_VALUE, v); check("R8", v, m_val);
    wr(A_CTRL, 1);                 // R5 start while running ignored
    rd(A_STAT, v);  check("R5", v, 1);
    idle(2);
    // R4 stop freezes count
    wr(A_CTRL, 2);
    rd(A_VALUE, held);
    rd(A_STAT, v);  check("R4", v, 0);
    idle(5);
    rd(A_VALUE, v); check("R4", v, held);
    wr(A_CTRL, 2);                 // R5 stop while idle ignored
    rd(A_STAT, v);  check("R5", v, 0);
    // R12 restart resumes from frozen value
    wr(A_CTRL, 1);
    rd(A_VALUE, v); check("R12", v, held);
    idle(40);
    rd(A_STAT, v);  check("R12", v, 0);

    // R9 prescaler zero: one step per cycle; stop on a step edge
    wr(A_PRESC, 0);
    wr(A_VALUE, 6);
    wr(A_CTRL, 3);                 // R5 value 3 starts when idle
    rd(A_VALUE, v); check("R9", v, 5);
    wr(A_CTRL, 3);                 // R5 value 3 stops when running
    rd(A_STAT, v);  check("R4", v, 0);
    held = m_val;
    idle(3);
    rd(A_VALUE, v); check("R4", v, held);

    // Long run to zero with larger prescaler
    wr(A_PRESC, 9);
    wr(A_VALUE, 20);
    wr(A_CTRL, 1);
    idle(250);
    rd(A_STAT, v);  check("R10", v, 0);
    rd(A_VALUE, v); check("R10", v, 0);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule